// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block sits in the command path of a DDR SDRAM controller. It accepts read requests one at a time. Each request names a bank, a row and a column. The block turns each request into a legal series of memory commands. It records, for every bank, whether a row is open and which row that is. From this record it picks the shortest path to the data:

- a plain READ when the requested row is already open;
- ACTIVE and then READ when the bank is closed;
- PRECHARGE, then ACTIVE, then READ when the bank holds a different row.

Per-bank down-counters enforce the precharge-to-activate time and the activate-to-read time. A single flag travels with each command. It tells the data path that the command ends the read burst still in flight. A burst counts as in flight for CAS latency plus half the burst length cycles after its READ. A READ to any bank cuts such a burst short. A PRECHARGE cuts it only when it closes the bank that burst came from.

Top module: `sdrs_read_seq`

## Requirements
- R1: After reset every bank is closed, the command lines carry NOP, `req_ready` is high and `cmd_cut` is low.
- R2: Commands are driven on {cs_n, ras_n, cas_n, we_n} as ACTIVE=0011, READ=0101, PRECHARGE=0010 and NOP=0111. NOP appears on every cycle without another command, and at most one command appears per cycle.
- R3: A request whose row is already open in its bank produces READ in the first cycle after acceptance, with no command before it.
- R4: A request to a bank holding a different row produces PRECHARGE to that bank in the first cycle after acceptance, ACTIVE exactly T_RP cycles later and READ exactly T_RCD cycles after the ACTIVE.
- R5: A request to a closed bank produces ACTIVE no earlier than the first cycle after acceptance and no earlier than T_RP cycles after that bank's last PRECHARGE, then READ exactly T_RCD cycles after the ACTIVE.
- R6: A request to a bank other than the one last read, whose requested row is open, issues READ directly, with no PRECHARGE or ACTIVE.
- R7: `cmd_cut` is high with a READ exactly when fewer than CAS_LAT + BURST_LEN/2 cycles have passed since the previous READ, unless a PRECHARGE has already cut that burst.
- R8: `cmd_cut` is high with a PRECHARGE exactly when a burst is in flight from the same bank. A PRECHARGE to any other bank leaves `cmd_cut` low and leaves the burst in flight.
- R9: `req_ready` falls in the cycle after a request is accepted. It stays low up to and including the READ cycle, and it is high again in the cycle that follows.
- R10: ACTIVE carries the request row on `cmd_addr`. READ carries the column zero-extended on `cmd_addr`. PRECHARGE carries zero. Every command other than NOP carries the request bank on `cmd_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_addr | output | max(ROW_W,COL_W) | Row, column or zero |
| cmd_cut | output | 1 | Issued command cuts the burst in flight short |

## Verification
Two functions can fall in the same cycle: issuing a PRECHARGE and ending the read burst that is still in flight. The bench provokes both orders. In one, a same-bank row miss follows a READ closely, so the PRECHARGE lands inside that burst's window and the cut flag must be high. In the other, a different-bank row miss arrives equally fast, so its PRECHARGE must leave the flag low. The bench judges each cycle against its own schedule, built from the last READ cycle and the bank it came from. A READ after a drained pause, with its flag low, shows that the window closes.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

  // Bit order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdrs_cmd_e;

  function automatic int sdrs_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Down-counter step: reload on event, otherwise count toward zero
  function automatic int tick_down(int cur, logic load, int load_val);
    if (load) return load_val;
    return (cur != 0) ? cur - 1 : 0;
  endfunction

  // Choice of the next command for the pending request
  function automatic sdrs_cmd_e pick_cmd(logic busy, logic bank_open, logic row_hit,
                                         logic rp_busy, logic rcd_busy);
    if (!busy)                          return CMD_NOP;
    if (bank_open && row_hit)           return rcd_busy ? CMD_NOP : CMD_RD;
    if (bank_open)                      return CMD_PRE;
    if (!rp_busy)                       return CMD_ACT;
    return CMD_NOP;
  endfunction

endpackage

// File: rtl/sdrs_bank_slot.sv
module sdrs_bank_slot
  import sdrs_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_pre,
  input  logic             do_act,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rp_busy,
  output logic             rcd_busy
);
  localparam int CW = $clog2(sdrs_max(T_RP, T_RCD) + 1);

  logic [CW-1:0] rp_cnt;
  logic [CW-1:0] rcd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      rp_cnt   <= '0;
      rcd_cnt  <= '0;
    end else begin
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= act_row;
      end else if (do_pre) begin
        is_open  <= 1'b0;
      end
      rp_cnt  <= CW'(tick_down(int'(rp_cnt),  do_pre, T_RP - 1));
      rcd_cnt <= CW'(tick_down(int'(rcd_cnt), do_act, T_RCD - 1));
    end
  end

  assign rp_busy  = (rp_cnt != '0);
  assign rcd_busy = (rcd_cnt != '0);

  AST_ACT_BANK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) do_act |-> (!is_open && !rp_busy)); // R5
  AST_PRE_BANK_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) do_pre |-> is_open); // R4
  AST_ACT_OPENS_ROW:   assert property (@(posedge clk) disable iff (!rst_n) do_act |=> (is_open && open_row == $past(act_row))); // R5

endmodule

// File: rtl/sdrs_burst_track.sv
module sdrs_burst_track
  import sdrs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int SPAN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_rd,
  input  logic              do_pre,
  input  logic [BANK_W-1:0] cmd_bank_i,
  output logic              in_flight,
  output logic [BANK_W-1:0] flight_bank
);
  localparam int SW = $clog2(SPAN + 1);

  logic [SW-1:0] left;
  logic          pre_kills;

  assign pre_kills = do_pre && (cmd_bank_i == flight_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left        <= '0;
      flight_bank <= '0;
    end else begin
      if (do_rd) begin
        flight_bank <= cmd_bank_i;
      end
      if (pre_kills && !do_rd) left <= '0;
      else                     left <= SW'(tick_down(int'(left), do_rd, SPAN - 1));
    end
  end

  assign in_flight = (left != '0);

  AST_PRE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n) (pre_kills && in_flight) |=> !in_flight); // R8
  AST_RD_STARTS_BURST: assert property (@(posedge clk) disable iff (!rst_n) do_rd |=> (in_flight && flight_bank == $past(cmd_bank_i))); // R7

endmodule

// File: rtl/sdrs_read_seq.sv
module sdrs_read_seq
  import sdrs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_cut
);
  localparam int SPAN = CAS_LAT + BURST_LEN / 2;

  logic              busy;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  logic             slot_open [NUM_BANKS];
  logic [ROW_W-1:0] slot_row  [NUM_BANKS];
  logic             slot_rp   [NUM_BANKS];
  logic             slot_rcd  [NUM_BANKS];

  sdrs_cmd_e   cmd;
  logic        do_rd, do_pre, do_act, accept;
  logic        in_flight;
  logic [BANK_W-1:0] flight_bank;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_bank <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cur_bank <= req_bank;
      cur_row  <= req_row;
      cur_col  <= req_col;
    end else if (do_rd) begin
      busy     <= 1'b0;
    end
  end

  assign cmd = pick_cmd(busy, slot_open[cur_bank], slot_row[cur_bank] == cur_row,
                        slot_rp[cur_bank], slot_rcd[cur_bank]);
  assign do_rd  = (cmd == CMD_RD);
  assign do_pre = (cmd == CMD_PRE);
  assign do_act = (cmd == CMD_ACT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdrs_bank_slot #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_pre   (do_pre && (cur_bank == BANK_W'(b))),
      .do_act   (do_act && (cur_bank == BANK_W'(b))),
      .act_row  (cur_row),
      .is_open  (slot_open[b]),
      .open_row (slot_row[b]),
      .rp_busy  (slot_rp[b]),
      .rcd_busy (slot_rcd[b])
    );
  end

  sdrs_burst_track #(.BANK_W(BANK_W), .SPAN(SPAN)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_rd       (do_rd),
    .do_pre      (do_pre),
    .cmd_bank_i  (cur_bank),
    .in_flight   (in_flight),
    .flight_bank (flight_bank)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
  assign cmd_bank = (cmd == CMD_NOP) ? '0 : cur_bank;
  assign cmd_cut  = in_flight && (do_rd || (do_pre && flight_bank == cur_bank));

  always_comb begin
    unique case (cmd)
      CMD_ACT: cmd_addr = ADDR_W'(cur_row);
      CMD_RD:  cmd_addr = ADDR_W'(cur_col);
      default: cmd_addr = '0;
    endcase
  end

  AST_ONE_CMD:        assert property (@(posedge clk) disable iff (!rst_n) $onehot0({do_rd, do_pre, do_act})); // R2
  AST_READY_DROPS:    assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready); // R9
  AST_READY_RETURNS:  assert property (@(posedge clk) disable iff (!rst_n) do_rd |=> req_ready); // R9
  AST_CUT_WITH_CMD:   assert property (@(posedge clk) disable iff (!rst_n) cmd_cut |-> (do_rd || do_pre)); // R7
  AST_REQ_HELD:       assert property (@(posedge clk) disable iff (!rst_n) (busy && !do_rd) |=> $stable(cur_bank) && $stable(cur_row)); // R9

endmodule

// File: tb/sdrs_read_seq_tb.sv
`timescale 1ns/1ps
module sdrs_read_seq_tb;
  localparam int NB = 4, RW = 12, CLW = 9, TRP = 3, TRCD = 3, CL = 2, BL = 4;
  localparam int SPAN = CL + BL / 2;
  localparam int AW = (RW > CLW) ? RW : CLW;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CLW-1:0] req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, cut;
  logic [1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;

  sdrs_read_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_cut(cut));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit m_open [NB];
  int m_row [NB], last_pre [NB], last_act [NB];
  int last_rd = -100, fbank = 0;
  bit flight = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_req(int b, int r, int c, int gap, string tag);
    int acc, pre_c, act_c, rd_c, ecmd, ecut, eaddr;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
    acc = cyc + 1;
    pre_c = -1; act_c = -1;
    if (m_open[b] && m_row[b] == r) begin
      rd_c = imax(acc, last_act[b] + TRCD);
    end else if (m_open[b]) begin
      pre_c = acc; act_c = pre_c + TRP; rd_c = act_c + TRCD;
    end else begin
      act_c = imax(acc, last_pre[b] + TRP); rd_c = act_c + TRCD;
    end
    req_valid = 1; req_bank = 2'(b); req_row = RW'(r); req_col = CLW'(c);
    @(negedge clk);
    req_valid = 0;
    for (int k = acc; k <= rd_c; k++) begin
      if (k != acc) @(negedge clk);
      ecut = 0; eaddr = 0;
      if (k == pre_c) begin
        ecmd = 4'b0010;
        ecut = (flight && (k - last_rd) < SPAN && fbank == b) ? 1 : 0;
        if (fbank == b) flight = 0;
        m_open[b] = 0; last_pre[b] = k;
      end else if (k == act_c) begin
        ecmd = 4'b0011; eaddr = r;
        m_open[b] = 1; m_row[b] = r; last_act[b] = k;
      end else if (k == rd_c) begin
        ecmd = 4'b0101; eaddr = c;
        ecut = (flight && (k - last_rd) < SPAN) ? 1 : 0;
        flight = 1; fbank = b; last_rd = k;
      end else begin
        ecmd = 4'b0111;
      end
      chk({cs_n, ras_n, cas_n, we_n} == 4'(ecmd), (ecmd == 4'b0111) ? "R2" : tag,
          $sformatf("command at offset %0d", k - acc), int'({cs_n, ras_n, cas_n, we_n}), ecmd);
      chk(cut == 1'(ecut), (ecmd == 4'b0010) ? "R8" : "R7", "cut flag", cut, ecut);
      chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
      if (ecmd != 4'b0111) begin
        chk(int'(cmd_bank) == b, "R10", "command bank", cmd_bank, b);
        chk(int'(cmd_addr) == eaddr, "R10", "command address", cmd_addr, eaddr);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "NOP after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(cut == 1'b0, "R1", "cut after reset", cut, 0);
  endtask

  // R5: closed bank, ACT then READ
  task automatic t_closed_bank();   do_req(0, 5, 3, 0, "R5");      endtask
  // R3: same open row, READ right away, cuts burst (R7)
  task automatic t_same_row();      do_req(0, 5, 8, 0, "R3");      endtask
  // R6: open a second bank after drain, then read the first bank's open row
  task automatic t_other_open();
    do_req(1, 7, 1, 6, "R5");
    do_req(0, 5, 12, 0, "R6");
  endtask
  // R4 and R8: same-bank miss during burst, PRE cuts it
  task automatic t_same_bank_miss(); do_req(0, 9, 4, 0, "R4");     endtask
  // R8: other-bank miss during burst, PRE leaves burst alone
  task automatic t_other_bank_miss(); do_req(1, 2, 6, 0, "R4");    endtask
  // R7: hit after the window drained, no cut; top column value, last bank
  task automatic t_drained();
    do_req(3, 4095, 511, 0, "R5");
    do_req(3, 4095, 17, 8, "R3");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_row[i] = 0; last_pre[i] = -100; last_act[i] = -100;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_closed_bank();
    t_same_row();
    t_other_open();
    t_same_bank_miss();
    t_other_bank_miss();
    t_drained();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule